// File: doc/BRIEF.md
# Character Input/Output Port with Ready Flags and Instruction Classifier

This block sits between a slow character device pair (a keyboard-like source and a printer-like sink) and a processor's accumulator. Each direction holds one 8-bit character register, and a one-bit ready flag guards it. The flag on the input side rises when the device delivers a character. It falls when the processor takes the character into its accumulator. While the flag is high, the device cannot overwrite the held character.

The flag on the output side has the opposite polarity. It is high while the sink is idle. A processor load moves the low byte of the accumulator into the output register and drops the flag. The sink raises the flag again once it has finished printing. Loads that arrive while the sink is busy have no effect.

The same block classifies a 16-bit instruction word. The class comes from the three opcode bits and the top bit. For a memory-reference word, the block also presents the addressing mode and the 12-bit address.

Top module: `charIo`

## Requirements
- R1: After reset the input flag is 0, the output flag is 1, and both character registers hold 0.
- R2: A device strobe while the input flag is 0 loads the device character into the input register and sets the input flag. Both changes are visible after the next clock edge.
- R3: A device strobe while the input flag is 1 is ignored. The input register keeps its character.
- R4: A processor take while the input flag is 1 clears the flag on that clock edge. A take while the flag is 0 changes nothing.
- R5: The accumulator-side output presents the input character in bits 7..0, with bits 15..8 at zero.
- R6: A processor output load while the output flag is 1 copies accumulator bits 7..0 into the output register and clears the output flag.
- R7: A processor output load while the output flag is 0 is ignored. The output register stays unchanged.
- R8: A device done pulse sets the output flag to 1, except when an accepted output load happens in the same cycle. In that case the load wins and the flag goes to 0.
- R9: A word whose bits 14..12 are not 111 is a memory reference. The indirect output equals bit 15, and the address output equals bits 11..0.
- R10: Bits 14..12 equal to 111 with bit 15 at 0 mark a register reference. With bit 15 at 1, they mark an input/output instruction.
- R11: Exactly one of the three class outputs is high for every instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devStrobe | input | 1 | Input device presents a character |
| devChar | input | 8 | Character from the input device |
| cpuTakeIn | input | 1 | Processor moves the input character to the accumulator |
| accOut | output | 16 | Zero-extended input character for the accumulator |
| inFlag | output | 1 | Input register holds an unread character |
| cpuLoadOut | input | 1 | Processor loads the output register from the accumulator |
| accIn | input | 16 | Accumulator value |
| devDone | input | 1 | Output device finished printing |
| outChar | output | 8 | Character to the output device |
| outFlag | output | 1 | Output register is free to load |
| instr | input | 16 | Instruction word to classify |
| isMemRef | output | 1 | Memory-reference class |
| isRegRef | output | 1 | Register-reference class |
| isIoRef | output | 1 | Input/output class |
| indirect | output | 1 | Addressing mode of a memory reference |
| addr | output | 12 | Address field |

## Verification
The hardest cases to reach are the ones where both sides of a handshake act in the same cycle. Examples are a device strobe that coincides with a processor take, and a done pulse that lands on the same edge as an accepted output load. In both cases the priority decides the result. Directed phases drive these collisions on purpose. A long pseudo-random phase then keeps all four handshake inputs active at once, so that collisions keep recurring while both flags are in each state. The behavioural model follows every edge and checks the flags and registers.

// File: rtl/charIoPkg.sv
package charIoPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadIn;
    logic loadOut;
  } ioStrobes_t;

  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_REG = 2'd1,
    CLS_IO  = 2'd2
  } instrClass_t;
endpackage

// File: rtl/charIoCtrl.sv
module charIoCtrl
  import charIoPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       devStrobe,
  input  logic       cpuTakeIn,
  input  logic       cpuLoadOut,
  input  logic       devDone,
  output logic       inFlag,
  output logic       outFlag,
  output ioStrobes_t strobes
);
  logic inFlagQ, outFlagQ;

  always_comb begin
    strobes.loadIn  = devStrobe && !inFlagQ;
    strobes.loadOut = cpuLoadOut && outFlagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlagQ  <= 1'b0;
      outFlagQ <= 1'b1;
    end else begin
      if (strobes.loadIn)
        inFlagQ <= 1'b1;
      else if (cpuTakeIn)
        inFlagQ <= 1'b0;

      if (strobes.loadOut)
        outFlagQ <= 1'b0;
      else if (devDone)
        outFlagQ <= 1'b1;
    end
  end

  assign inFlag  = inFlagQ;
  assign outFlag = outFlagQ;
endmodule

// File: rtl/charIoData.sv
module charIoData
  import charIoPkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        strobes,
  input  logic [CHAR_W-1:0] devChar,
  input  logic [ACC_W-1:0]  accIn,
  output logic [ACC_W-1:0]  accOut,
  output logic [CHAR_W-1:0] outChar
);
  localparam int PAD_W = ACC_W - CHAR_W;

  logic [CHAR_W-1:0] inReg, outReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg  <= '0;
      outReg <= '0;
    end else begin
      if (strobes.loadIn)  inReg  <= devChar;
      if (strobes.loadOut) outReg <= accIn[CHAR_W-1:0];
    end
  end

  assign accOut  = {{PAD_W{1'b0}}, inReg};
  assign outChar = outReg;
endmodule

// File: rtl/charIoDecode.sv
module charIoDecode
  import charIoPkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int ADDR_W  = 12,
  parameter int OP_W    = 3
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               isMemRef,
  output logic               isRegRef,
  output logic               isIoRef,
  output logic               indirect,
  output logic [ADDR_W-1:0]  addr
);
  localparam int MODE_BIT = INSTR_W - 1;
  localparam int OP_HI    = INSTR_W - 2;

  logic [OP_W-1:0] opField;
  instrClass_t     cls;

  assign opField = instr[OP_HI -: OP_W];

  always_comb begin
    if (opField != {OP_W{1'b1}})
      cls = CLS_MEM;
    else if (instr[MODE_BIT])
      cls = CLS_IO;
    else
      cls = CLS_REG;
  end

  assign isMemRef = (cls == CLS_MEM);
  assign isRegRef = (cls == CLS_REG);
  assign isIoRef  = (cls == CLS_IO);
  assign indirect = instr[MODE_BIT];
  assign addr     = instr[ADDR_W-1:0];
endmodule

// File: rtl/charIo.sv
module charIo
  import charIoPkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int ACC_W   = 16,
  parameter int INSTR_W = 16,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               devStrobe,
  input  logic [CHAR_W-1:0]  devChar,
  input  logic               cpuTakeIn,
  output logic [ACC_W-1:0]   accOut,
  output logic               inFlag,
  input  logic               cpuLoadOut,
  input  logic [ACC_W-1:0]   accIn,
  input  logic               devDone,
  output logic [CHAR_W-1:0]  outChar,
  output logic               outFlag,
  input  logic [INSTR_W-1:0] instr,
  output logic               isMemRef,
  output logic               isRegRef,
  output logic               isIoRef,
  output logic               indirect,
  output logic [ADDR_W-1:0]  addr
);
  ioStrobes_t strobes;

  charIoCtrl uCtrl (
    .clk(clk), .rstN(rstN), .devStrobe(devStrobe), .cpuTakeIn(cpuTakeIn),
    .cpuLoadOut(cpuLoadOut), .devDone(devDone), .inFlag(inFlag),
    .outFlag(outFlag), .strobes(strobes)
  );

  charIoData #(.CHAR_W(CHAR_W), .ACC_W(ACC_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .devChar(devChar),
    .accIn(accIn), .accOut(accOut), .outChar(outChar)
  );

  charIoDecode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) uDec (
    .instr(instr), .isMemRef(isMemRef), .isRegRef(isRegRef),
    .isIoRef(isIoRef), .indirect(indirect), .addr(addr)
  );
endmodule

// File: rtl/charIoChecker.sv
module charIoChecker #(
  parameter int CHAR_W = 8,
  parameter int ACC_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              devStrobe,
  input logic [CHAR_W-1:0] devChar,
  input logic              cpuTakeIn,
  input logic [ACC_W-1:0]  accOut,
  input logic              inFlag,
  input logic              cpuLoadOut,
  input logic [ACC_W-1:0]  accIn,
  input logic              devDone,
  input logic [CHAR_W-1:0] outChar,
  input logic              outFlag,
  input logic              isMemRef,
  input logic              isRegRef,
  input logic              isIoRef
);
  a_r2_accept_char: assert property (@(posedge clk) disable iff (!rstN)
    devStrobe && !inFlag |=> inFlag && accOut[CHAR_W-1:0] == $past(devChar));

  a_r3_hold_char: assert property (@(posedge clk) disable iff (!rstN)
    devStrobe && inFlag |=> $stable(accOut));

  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rstN)
    cpuTakeIn && inFlag |=> !inFlag);

  a_r6_load_out: assert property (@(posedge clk) disable iff (!rstN)
    cpuLoadOut && outFlag |=> !outFlag && outChar == $past(accIn[CHAR_W-1:0]));

  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    cpuLoadOut && !outFlag |=> $stable(outChar));

  a_r8_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    devDone && !(cpuLoadOut && outFlag) |=> outFlag);

  a_r11_one_class: assert property (@(posedge clk) disable iff (!rstN)
    $countones({isMemRef, isRegRef, isIoRef}) == 1);
endmodule

bind charIo charIoChecker #(.CHAR_W(CHAR_W), .ACC_W(ACC_W)) uChk (
  .clk(clk), .rstN(rstN), .devStrobe(devStrobe), .devChar(devChar),
  .cpuTakeIn(cpuTakeIn), .accOut(accOut), .inFlag(inFlag),
  .cpuLoadOut(cpuLoadOut), .accIn(accIn), .devDone(devDone),
  .outChar(outChar), .outFlag(outFlag), .isMemRef(isMemRef),
  .isRegRef(isRegRef), .isIoRef(isIoRef)
);

// File: tb/tb_charIo.sv
module tb_charIo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devStrobe = 1'b0;
  logic [7:0]  devChar = '0;
  logic        cpuTakeIn = 1'b0;
  logic [15:0] accOut;
  logic        inFlag;
  logic        cpuLoadOut = 1'b0;
  logic [15:0] accIn = '0;
  logic        devDone = 1'b0;
  logic [7:0]  outChar;
  logic        outFlag;
  logic [15:0] instr = '0;
  logic        isMemRef, isRegRef, isIoRef, indirect;
  logic [11:0] addr;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int mIn = 0, mInFlag = 0, mOut = 0, mOutFlag = 1;
  bit compareOn = 0;

  always #10 clk = ~clk;

  charIo dut (
    .clk(clk), .rstN(rstN), .devStrobe(devStrobe), .devChar(devChar),
    .cpuTakeIn(cpuTakeIn), .accOut(accOut), .inFlag(inFlag),
    .cpuLoadOut(cpuLoadOut), .accIn(accIn), .devDone(devDone),
    .outChar(outChar), .outFlag(outFlag), .instr(instr),
    .isMemRef(isMemRef), .isRegRef(isRegRef), .isIoRef(isIoRef),
    .indirect(indirect), .addr(addr)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural model, updated on each edge from the inputs driven at negedge
  always @(posedge clk) begin
    if (!rstN) begin
      mIn = 0; mInFlag = 0; mOut = 0; mOutFlag = 1;
    end else begin
      if (devStrobe && mInFlag == 0) begin
        mIn = devChar; mInFlag = 1;
      end else if (cpuTakeIn) mInFlag = 0;
      if (cpuLoadOut && mOutFlag == 1) begin
        mOut = accIn & 8'hff; mOutFlag = 0;
      end else if (devDone) mOutFlag = 1;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (compareOn) begin
      chk("R2/R4 inFlag", int'(inFlag), mInFlag);
      chk("R3/R5 accOut", int'(accOut), mIn);
      chk("R6/R8 outFlag", int'(outFlag), mOutFlag);
      chk("R7 outChar", int'(outChar), mOut);
    end
  end

  task automatic cyc(bit ds, int dc, bit tk, bit lo, int ac, bit dn);
    devStrobe = ds; devChar = dc[7:0]; cpuTakeIn = tk;
    cpuLoadOut = lo; accIn = ac[15:0]; devDone = dn;
    @(negedge clk);
  endtask

  task automatic chkDecode(logic [15:0] w);
    int cls;
    instr = w;
    #1;
    if (w[14:12] != 3'b111) cls = 0; else if (w[15]) cls = 2; else cls = 1;
    chk("R9/R10 mem", int'(isMemRef), int'(cls == 0));
    chk("R10 reg", int'(isRegRef), int'(cls == 1));
    chk("R10 io", int'(isIoRef), int'(cls == 2));
    chk("R11 count", int'(isMemRef) + int'(isRegRef) + int'(isIoRef), 1);
    if (cls == 0) begin
      chk("R9 indirect", int'(indirect), int'(w[15]));
      chk("R9 addr", int'(addr), int'(w[11:0]));
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 inFlag", int'(inFlag), 0);
    chk("R1 outFlag", int'(outFlag), 1);
    chk("R1 accOut", int'(accOut), 0);
    chk("R1 outChar", int'(outChar), 0);
    compareOn = 1;
    // R2 deliver, R3 overwrite attempt, R4 take, take while empty
    cyc(1, 8'h41, 0, 0, 0, 0);
    chk("R2 flag set", int'(inFlag), 1);
    chk("R5 zero-extended", int'(accOut), 16'h0041);
    cyc(1, 8'h5a, 0, 0, 0, 0);
    chk("R3 kept", int'(accOut), 16'h0041);
    cyc(1, 8'h77, 1, 0, 0, 0);
    chk("R4 cleared", int'(inFlag), 0);
    chk("R3 collide kept", int'(accOut), 16'h0041);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R4 idle take", int'(inFlag), 0);
    cyc(1, 8'hc3, 1, 0, 0, 0);
    chk("R2 strobe wins empty", int'(inFlag), 1);
    // R6 load, R7 busy, R8 done
    cyc(0, 0, 0, 1, 16'hab12, 0);
    chk("R6 char", int'(outChar), 8'h12);
    chk("R6 flag", int'(outFlag), 0);
    cyc(0, 0, 0, 1, 16'h00ee, 0);
    chk("R7 ignored", int'(outChar), 8'h12);
    cyc(0, 0, 0, 1, 16'h0099, 1);
    chk("R8 done sets", int'(outFlag), 1);
    chk("R7 still", int'(outChar), 8'h12);
    cyc(0, 0, 0, 1, 16'h0034, 1);
    chk("R8 load wins", int'(outFlag), 0);
    chk("R6 collide char", int'(outChar), 8'h34);
    // random phase
    lfsr = 16'hace1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], int'(lfsr[15:8]), lfsr[1] & lfsr[5], lfsr[2],
          int'({lfsr[7:0], lfsr[15:8]}), lfsr[3] & lfsr[6]);
    end
    // reset mid-run returns to R1 state
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 re-reset inFlag", int'(inFlag), 0);
    chk("R1 re-reset outFlag", int'(outFlag), 1);
    compareOn = 0;
    // decoder
    chkDecode(16'h1abc);
    chkDecode(16'h9fff);
    chkDecode(16'h6000);
    chkDecode(16'h7200);
    chkDecode(16'hf800);
    chkDecode(16'he123);
    chkDecode(16'h7000);
    chkDecode(16'hffff);
    for (int w = 0; w < 65536; w += 997) chkDecode(w[15:0]);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule